// File: doc/BRIEF.md
# NAND Bad-Block Skipping Page Walker

This block sequences boot-page fetches from a NAND flash through a separate page-read engine. After a start pulse it visits erase blocks in ascending order, beginning at block 0. Its first load in each block is page 0 read at the spare-area column, which returns the factory bad-block marker byte. A block whose marker is not 0xFF is passed over without any data request. In a good block, pages are requested in ascending order at column 0. The good pages delivered are counted, so the logical page sequence is contiguous across good blocks only.

The walk finishes with a one-cycle `done` once the requested number of good pages has been delivered. It finishes with a one-cycle `fail` when any load reports an uncorrectable ECC error, or when the last block has been passed without collecting enough pages. The caller can then take a fallback path.

The state machine has six states:
- `ST_IDLE` waits for start.
- `ST_MARK` holds the marker request.
- `ST_DATA` holds a data-page request.
- `ST_SKIP` advances to the next block.
- `ST_DONE` and `ST_FAIL` are the strobes.

Its transitions are:
- idle→done when zero pages are asked for.
- idle→mark on start.
- mark→fail on an ECC error.
- mark→skip on a bad marker.
- mark→data on a good marker.
- data→fail on an ECC error.
- data→done when the count is reached.
- data→skip after the last page of a block.
- data→data otherwise.
- skip→fail past the last block.
- skip→mark otherwise.
- done/fail→idle.

Only single-plane devices are handled. The configuration inputs must stay stable while a walk is in progress.

Top module: `nand_page_walker`

## Requirements
- R1: While reset is held and right after it is released, `req_valid`, `done` and `fail` are low.
- R2: One cycle after `start` (with `need_pages` nonzero), a request for block 0, page 0 appears at the spare column. The spare column is 2048 when `page_4k`=0 and 4096 when `page_4k`=1.
- R3: After a marker load returns 0xFF, the block's pages 0 to 2^`ppb_log2`−1 are requested in ascending order at column 0, and no page index above 2^`ppb_log2`−1 is ever requested.
- R4: A marker byte other than 0xFF makes the block skipped. The next cycle carries no request, and the next request is the marker read of the following block.
- R5: `req_row` equals `req_block` × 2^`ppb_log2` + `req_page`.
- R6: A request's block, page, row and column stay unchanged until `pg_done` is sampled high while `req_valid` is high.
- R7: `pg_ecc_fail` high together with `pg_done`, on a marker or data load (and even for a block marked bad), gives `fail` in the next cycle and no further request.
- R8: `done` rises in the cycle after the handshake of the `need_pages`-th good data page. With `need_pages`=0, `done` rises one cycle after `start` and no request is made.
- R9: When the last block (`MAX_BLOCKS`−1) is finished or skipped before enough pages are collected, `fail` rises two cycles after that block's final handshake.
- R10: `done` and `fail` each last exactly one cycle, are never high together and coincide with no request, and the block accepts a new start afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a walk when idle |
| need_pages | input | CNT_W | Number of good data pages to collect |
| ppb_log2 | input | LG_W | log2 of pages per block (0 to PG_W) |
| page_4k | input | 1 | Page size select: 0 = 2 KB, 1 = 4 KB |
| req_valid | output | 1 | A page load is requested |
| req_block | output | BLK_W | Block index of the request |
| req_page | output | PG_W | Page index within the block |
| req_row | output | ROW_W | Flat row address |
| req_col | output | COL_W | Column address (spare start for marker loads, 0 for data) |
| pg_done | input | 1 | Page engine finished the current load |
| pg_ecc_fail | input | 1 | Uncorrectable ECC error on that load |
| pg_marker | input | 8 | Marker byte returned by a spare-area load |
| done | output | 1 | One-cycle strobe: all requested pages delivered |
| fail | output | 1 | One-cycle strobe: ECC error or blocks exhausted |

## Verification
Timing is counted from the falling edge at which the bench drives a stimulus:
- The first request is due at the next falling edge after `start`.
- A new request, or `done`, or an ECC-triggered `fail`, is due at the falling edge after the one carrying `pg_done`.
- A skip costs one idle cycle, so the next marker request and the exhausted-blocks `fail` arrive one falling edge later.

The bench samples at exactly those edges. It also checks that the cycle before `fail` on exhaustion carries no strobe, and that each strobe has cleared by the following edge. The sweep covers every pages-per-block setting of a small configuration, several bad-block masks and a range of page counts, with each expected request computed arithmetically.

// File: rtl/npw_pkg.sv
package npw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_DATA,
        ST_SKIP,
        ST_DONE,
        ST_FAIL
    } npw_state_e;

    localparam logic [7:0] MARK_GOOD = 8'hFF;

endpackage

// File: rtl/npw_addr.sv
module npw_addr #(
    parameter int BLK_W      = 10,
    parameter int PG_W       = 6,
    parameter int LG_W       = 3,
    parameter int COL_W      = 13,
    parameter int SMALL_PAGE = 2048,
    localparam int ROW_W     = BLK_W + PG_W
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [PG_W-1:0]  pg,
    input  logic [LG_W-1:0]  lg,
    input  logic             spare,
    input  logic             page_4k,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);

    localparam logic [COL_W-1:0] SPARE_SMALL = COL_W'(SMALL_PAGE);
    localparam logic [COL_W-1:0] SPARE_LARGE = COL_W'(2 * SMALL_PAGE);

    // Pages per block is a power of two, so the row is a shift plus an OR.
    always_comb begin
        row = (ROW_W'(blk) << lg) | ROW_W'(pg);
        if (spare) begin
            col = page_4k ? SPARE_LARGE : SPARE_SMALL;
        end else begin
            col = '0;
        end
    end

endmodule

// File: rtl/npw_limits.sv
module npw_limits #(
    parameter int MAX_BLOCKS = 1024,
    parameter int PG_W       = 6,
    parameter int LG_W       = 3,
    localparam int BLK_W     = $clog2(MAX_BLOCKS)
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [PG_W-1:0]  pg,
    input  logic [LG_W-1:0]  lg,
    output logic [PG_W:0]    ppb_m1,
    output logic             pg_last,
    output logic             blk_last
);

    always_comb begin
        ppb_m1   = ((PG_W+1)'(1) << lg) - (PG_W+1)'(1);
        pg_last  = ({1'b0, pg} == ppb_m1);
        blk_last = (blk == BLK_W'(MAX_BLOCKS - 1));
    end

endmodule

// File: rtl/nand_page_walker.sv
module nand_page_walker
    import npw_pkg::*;
#(
    parameter int MAX_BLOCKS = 1024,
    parameter int PG_W       = 6,
    parameter int CNT_W      = 16,
    parameter int SMALL_PAGE = 2048,
    localparam int BLK_W     = $clog2(MAX_BLOCKS),
    localparam int LG_W      = $clog2(PG_W + 1),
    localparam int ROW_W     = BLK_W + PG_W,
    localparam int COL_W     = $clog2(2 * SMALL_PAGE) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] need_pages,
    input  logic [LG_W-1:0]  ppb_log2,
    input  logic             page_4k,
    output logic             req_valid,
    output logic [BLK_W-1:0] req_block,
    output logic [PG_W-1:0]  req_page,
    output logic [ROW_W-1:0] req_row,
    output logic [COL_W-1:0] req_col,
    input  logic             pg_done,
    input  logic             pg_ecc_fail,
    input  logic [7:0]       pg_marker,
    output logic             done,
    output logic             fail
);

    npw_state_e       st_q, st_nxt;
    logic [BLK_W-1:0] blk_q;
    logic [PG_W-1:0]  pg_q;
    logic [CNT_W-1:0] got_q;
    logic [CNT_W-1:0] got_inc;
    logic [PG_W:0]    ppb_m1;
    logic             pg_last;
    logic             blk_last;
    logic             spare_sel;

    assign got_inc = got_q + 1'b1;

    npw_limits #(
        .MAX_BLOCKS (MAX_BLOCKS),
        .PG_W       (PG_W),
        .LG_W       (LG_W)
    ) u_limits (
        .blk      (blk_q),
        .pg       (pg_q),
        .lg       (ppb_log2),
        .ppb_m1   (ppb_m1),
        .pg_last  (pg_last),
        .blk_last (blk_last)
    );

    npw_addr #(
        .BLK_W      (BLK_W),
        .PG_W       (PG_W),
        .LG_W       (LG_W),
        .COL_W      (COL_W),
        .SMALL_PAGE (SMALL_PAGE)
    ) u_addr (
        .blk     (blk_q),
        .pg      (pg_q),
        .lg      (ppb_log2),
        .spare   (spare_sel),
        .page_4k (page_4k),
        .row     (req_row),
        .col     (req_col)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_nxt = (need_pages == '0) ? ST_DONE : ST_MARK;
                end
            end
            ST_MARK: begin
                if (pg_done) begin
                    if (pg_ecc_fail) begin
                        st_nxt = ST_FAIL;
                    end else if (pg_marker != MARK_GOOD) begin
                        st_nxt = ST_SKIP;
                    end else begin
                        st_nxt = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (pg_done) begin
                    if (pg_ecc_fail) begin
                        st_nxt = ST_FAIL;
                    end else if (got_inc == need_pages) begin
                        st_nxt = ST_DONE;
                    end else if (pg_last) begin
                        st_nxt = ST_SKIP;
                    end
                end
            end
            ST_SKIP: st_nxt = blk_last ? ST_FAIL : ST_MARK;
            ST_DONE: st_nxt = ST_IDLE;
            ST_FAIL: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Block, page and delivered-page counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
            pg_q  <= '0;
            got_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        blk_q <= '0;
                        pg_q  <= '0;
                        got_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (pg_done && !pg_ecc_fail) begin
                        got_q <= got_inc;
                        if (!pg_last) begin
                            pg_q <= pg_q + 1'b1;
                        end
                    end
                end
                ST_SKIP: begin
                    if (!blk_last) begin
                        blk_q <= blk_q + 1'b1;
                        pg_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_valid = 1'b0;
        spare_sel = 1'b0;
        done      = 1'b0;
        fail      = 1'b0;
        unique case (st_q)
            ST_MARK: begin
                req_valid = 1'b1;
                spare_sel = 1'b1;
            end
            ST_DATA: req_valid = 1'b1;
            ST_DONE: done = 1'b1;
            ST_FAIL: fail = 1'b1;
            default: ;
        endcase
        req_block = blk_q;
        req_page  = pg_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !pg_done |=> req_valid && $stable(req_row) && $stable(req_col)); // R6
    AST_ECC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && pg_done && pg_ecc_fail |=> fail && !req_valid); // R7
    AST_BAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_col != '0) && pg_done && !pg_ecc_fail && (pg_marker != MARK_GOOD)
        |=> !req_valid && !done && !fail); // R4
    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_page} <= ppb_m1)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail) && !((done || fail) && req_valid)); // R10
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_FAIL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail); // R10

endmodule

// File: tb/nand_page_walker_bench.sv
module nand_page_walker_bench;

    localparam int NBLK  = 8;
    localparam int PG_W  = 3;
    localparam int CNT_W = 8;
    localparam int BLK_W = $clog2(NBLK);
    localparam int LG_W  = $clog2(PG_W + 1);
    localparam int ROW_W = BLK_W + PG_W;
    localparam int COL_W = $clog2(4096) + 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [CNT_W-1:0] need_pages;
    logic [LG_W-1:0]  ppb_log2;
    logic             page_4k;
    logic             req_valid;
    logic [BLK_W-1:0] req_block;
    logic [PG_W-1:0]  req_page;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             pg_done;
    logic             pg_ecc_fail;
    logic [7:0]       pg_marker;
    logic             done;
    logic             fail;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    nand_page_walker #(
        .MAX_BLOCKS (NBLK),
        .PG_W       (PG_W),
        .CNT_W      (CNT_W),
        .SMALL_PAGE (2048)
    ) u_nand_page_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .need_pages  (need_pages),
        .ppb_log2    (ppb_log2),
        .page_4k     (page_4k),
        .req_valid   (req_valid),
        .req_block   (req_block),
        .req_page    (req_page),
        .req_row     (req_row),
        .req_col     (req_col),
        .pg_done     (pg_done),
        .pg_ecc_fail (pg_ecc_fail),
        .pg_marker   (pg_marker),
        .done        (done),
        .fail        (fail)
    );

    task automatic check(input bit c, input string r, input string what, input int act, input int exp);
        n_run++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic expect_end(input bit want_done, input int dly, input string tag);
        repeat (dly) begin
            check(!done && !fail, tag, "no strobe before due cycle", int'(done | fail), 0);
            @(negedge clk);
        end
        if (want_done) begin
            check(done == 1'b1, tag, "done strobe", int'(done), 1);
            check(fail == 1'b0, "R10", "fail low with done", int'(fail), 0);
        end else begin
            check(fail == 1'b1, tag, "fail strobe", int'(fail), 1);
            check(done == 1'b0, "R10", "done low with fail", int'(done), 0);
        end
        check(req_valid == 1'b0, "R10", "no request with strobe", int'(req_valid), 0);
        @(negedge clk);
        check(!done && !fail, "R10", "strobe lasts one cycle", int'(done | fail), 0);
    endtask

    task automatic serve(input int b, input int p, input int lg, input bit spare,
                         input logic [7:0] mk, input bit e);
        int w;
        int lat;
        int exp_row;
        int exp_col;
        w = 0;
        exp_row = b * (1 << lg) + p;
        exp_col = spare ? ((lg % 2 == 1) ? 4096 : 2048) : 0;
        while (!req_valid && w < 6) begin
            @(negedge clk);
            w++;
        end
        check(req_valid == 1'b1, spare ? "R4" : "R3", "request present", int'(req_valid), 1);
        check(int'(req_block) == b, spare ? "R4" : "R3", "block index", int'(req_block), b);
        check(int'(req_page) == p, "R3", "page index", int'(req_page), p);
        check(int'(req_col) == exp_col, spare ? "R2" : "R3", "column", int'(req_col), exp_col);
        check(int'(req_row) == exp_row, "R5", "row address", int'(req_row), exp_row);
        lat = (b + p + lg) % 3;
        repeat (lat) begin
            @(negedge clk);
            check(req_valid && int'(req_row) == exp_row && int'(req_col) == exp_col,
                  "R6", "request held", int'(req_row), exp_row);
        end
        pg_done     = 1'b1;
        pg_ecc_fail = e;
        pg_marker   = mk;
        @(negedge clk);
        pg_done     = 1'b0;
        pg_ecc_fail = 1'b0;
        pg_marker   = 8'h00;
    endtask

    // eb: block carrying an ECC error (-1 for none); ep: page, -1 for the marker load
    task automatic run_case(input logic [7:0] bad, input int nd, input int lg,
                            input int eb, input int ep);
        int  got;
        bit  fin;
        got = 0;
        fin = 1'b0;
        @(negedge clk);
        need_pages = CNT_W'(nd);
        ppb_log2   = LG_W'(lg);
        page_4k    = (lg % 2 == 1);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        if (nd == 0) begin
            check(req_valid == 1'b0, "R8", "no request for zero pages", int'(req_valid), 0);
            expect_end(1'b1, 0, "R8");
            return;
        end
        check(req_valid == 1'b1, "R2", "first request one cycle after start", int'(req_valid), 1);
        for (int b = 0; b < NBLK && !fin; b++) begin
            logic [7:0] mk;
            bit         e;
            mk = bad[b] ? ((b % 2 == 1) ? 8'hFE : 8'h00) : 8'hFF;
            e  = (eb == b) && (ep < 0);
            serve(b, 0, lg, 1'b1, mk, e);
            if (e) begin
                expect_end(1'b0, 0, "R7");
                fin = 1'b1;
            end else if (bad[b]) begin
                check(req_valid == 1'b0, "R4", "no request after bad marker", int'(req_valid), 0);
            end else begin
                for (int p = 0; p < (1 << lg) && !fin; p++) begin
                    bit e2;
                    e2 = (eb == b) && (ep == p);
                    serve(b, p, lg, 1'b0, 8'h5A, e2);
                    if (e2) begin
                        expect_end(1'b0, 0, "R7");
                        fin = 1'b1;
                    end else begin
                        got++;
                        if (got == nd) begin
                            expect_end(1'b1, 0, "R8");
                            fin = 1'b1;
                        end
                    end
                end
            end
        end
        if (!fin) begin
            expect_end(1'b0, 1, "R9");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] masks [5];
        masks[0] = 8'h00;
        masks[1] = 8'h01;
        masks[2] = 8'hA5;
        masks[3] = 8'h80;
        masks[4] = 8'hFE;
        rst_n       = 1'b0;
        start       = 1'b0;
        need_pages  = '0;
        ppb_log2    = '0;
        page_4k     = 1'b0;
        pg_done     = 1'b0;
        pg_ecc_fail = 1'b0;
        pg_marker   = 8'h00;
        repeat (3) @(negedge clk);
        check(!req_valid && !done && !fail, "R1", "outputs low in reset",
              int'(req_valid | done | fail), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && !done && !fail, "R1", "outputs low after reset",
              int'(req_valid | done | fail), 0);

        for (int lg = 0; lg <= PG_W; lg++) begin
            for (int m = 0; m < 5; m++) begin
                int good;
                int ppb;
                int total;
                int needs [6];
                good = 0;
                for (int b = 0; b < NBLK; b++) good += masks[m][b] ? 0 : 1;
                ppb   = 1 << lg;
                total = good * ppb;
                needs[0] = 0;
                needs[1] = 1;
                needs[2] = ppb;
                needs[3] = ppb + 1;
                needs[4] = total;
                needs[5] = total + 1;
                for (int k = 0; k < 6; k++) begin
                    if (!(k == 4 && total == 0)) begin
                        run_case(masks[m], needs[k], lg, -1, 0);
                    end
                end
            end
        end

        // ECC abort cases (R7)
        run_case(8'h00, 20, 2, 2, -1);
        run_case(8'h04, 20, 2, 1, 3);
        run_case(8'h02, 20, 1, 1, -1);
        run_case(8'h00, 5, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule